// File: doc/BRIEF.md
# BCH8 Error Location Corrector

This block finishes the correction of one 512-byte sector after an 8-bit-correcting BCH engine has finished its syndrome work. On a start pulse it captures the engine's status word and three result words and reads the error count from the status word. With a count from 1 to 8 it unpacks 13-bit bit positions, which are packed without gaps across the words. It inverts the two low bits of each position and flips the addressed bits in an external sector buffer. Each flip is a read followed by a write on a byte-wide port, one access per clock.

A count above 8 normally means the sector cannot be corrected. A freshly erased page also produces such a count, because its spare area is all ones. For that case the block counts the zero bits in the 13 stored code bytes and in the data. If only a few zero bits are present, it treats the sector as erased: it forces every data byte to 0xFF and reports how many data bits were repaired. Otherwise it flags the sector as uncorrectable. A busy/done handshake frames each sector.

Top module: `bch8_err_fix`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low. The buffer port is never used while busy_o is low.
- R2: The error count is sts_i[13:10]. A count of 0 produces done with result_o = 0 and uncorr_o = 0, and the buffer is left untouched.
- R3: Positions are 13-bit fields of the 104-bit vector {sts_i[23:16], ecc3_i, ecc2_i, ecc1_i}. Position k occupies bits [13k+12:13k]. All other status bits are ignored.
- R4: Bits 1:0 of every field are inverted before use. The resulting position p flips bit p[2:0] of byte p[12:3], with bit 0 as the least significant bit.
- R5: With a count n from 1 to 8, positions 0..n-1 are applied in index order. The first position at or above 4096 ends the correction. result_o is the number of bits actually flipped, and uncorr_o = 0.
- R6: A count of 9 or more starts the erased check. The check adds the zero bits of stored_ecc_i (13 bytes) to the zero bits of all 512 data bytes. If the total is 8 or less, every data byte becomes 0xFF, result_o is the number of zero data bits, and uncorr_o = 0.
- R7: If that total exceeds 8, uncorr_o = 1, result_o = 0, and no byte of the buffer is written.
- R8: A start is taken only while busy_o is low. busy_o is high from the cycle after an accepted start through the one-cycle done_o pulse. result_o and uncorr_o hold until the next start.
- R9: Each flip reads a byte, and on the next cycle writes it back to the same address. Read data arrives one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one sector |
| sts_i | input | 32 | Engine status word (count, top position byte) |
| ecc1_i | input | 32 | Engine result word 1 |
| ecc2_i | input | 32 | Engine result word 2 |
| ecc3_i | input | 32 | Engine result word 3 |
| stored_ecc_i | input | 104 | 13 code bytes from the spare area, byte k at [8k+7:8k] |
| busy_o | output | 1 | Sector in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 4 | Number of corrected bits |
| uncorr_o | output | 1 | Sector uncorrectable |
| mem_req_o | output | 1 | Buffer access request |
| mem_we_o | output | 1 | Buffer write enable |
| mem_addr_o | output | 9 | Buffer byte address |
| mem_wdata_o | output | 8 | Buffer write data |
| mem_rdata_i | input | 8 | Buffer read data, one cycle after request |

## Verification
Directed position sets cover the first and last bit of the sector and each field that straddles a word boundary. Together they separate a correct unpack from one that is shifted or that skips the bit inversion. Duplicate positions confirm that flips are true read-modify-writes and not plain sets. A position that is out of range placed partway through the list confirms that processing stops there and does not skip over it. Erased-page patterns use zero-bit totals of 8, 9 and above, split between the stored bytes and the data, which isolates the threshold and the fill-versus-flag decision. Random valid sets and random erased patterns are checked against a bench model of the whole buffer.

// File: rtl/bch8_fix_pkg.sv
package bch8_fix_pkg;
  localparam int unsigned NPOS  = 8;
  localparam int unsigned POS_W = 13;
  localparam int unsigned VEC_W = NPOS * POS_W;
  localparam int unsigned CODE_BYTES = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIX_RD, ST_FIX_WR, ST_SCAN_RD, ST_SCAN_CHK, ST_FILL, ST_DONE
  } fix_state_e;
endpackage

// File: rtl/bch8_pos_unpack.sv
module bch8_pos_unpack
  import bch8_fix_pkg::*;
#(
  parameter int unsigned SECT_BYTES = 512
) (
  input  logic [VEC_W-1:0]            vec_i,
  output logic [NPOS-1:0][POS_W-1:0]  pos_o,
  output logic [NPOS-1:0]             valid_o
);
  localparam logic [POS_W:0] LIMIT = (POS_W+1)'(SECT_BYTES * 8);

  for (genvar k = 0; k < NPOS; k++) begin : g_pos
    assign pos_o[k]   = vec_i[k*POS_W +: POS_W] ^ POS_W'(3);
    assign valid_o[k] = {1'b0, pos_o[k]} < LIMIT;
  end
endmodule

// File: rtl/bch8_zero_count.sv
module bch8_zero_count #(
  parameter int unsigned NBYTES = 1,
  localparam int unsigned NBITS = NBYTES * 8,
  localparam int unsigned CW = $clog2(NBITS + 1)
) (
  input  logic [NBITS-1:0] bytes_i,
  output logic [CW-1:0]    zeros_o
);
  always_comb begin
    zeros_o = '0;
    for (int b = 0; b < NBITS; b++) zeros_o = zeros_o + CW'(!bytes_i[b]);
  end
endmodule

// File: rtl/bch8_err_fix.sv
module bch8_err_fix
  import bch8_fix_pkg::*;
#(
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned MAX_FIX = 8,
  localparam int unsigned ADDR_W = $clog2(SECT_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [31:0]             sts_i,
  input  logic [31:0]             ecc1_i,
  input  logic [31:0]             ecc2_i,
  input  logic [31:0]             ecc3_i,
  input  logic [CODE_BYTES*8-1:0] stored_ecc_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [3:0]              result_o,
  output logic                    uncorr_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  input  logic [7:0]              mem_rdata_i
);
  localparam int unsigned ECW = $clog2(CODE_BYTES * 8 + 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SECT_BYTES - 1);

  fix_state_e               state_q;
  logic [VEC_W-1:0]         vec_q;
  logic [3:0]               left_q, applied_q, ez_q, res_q;
  logic [2:0]               idx_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [4:0]               dz_q;
  logic                     uncorr_q;

  logic [NPOS-1:0][POS_W-1:0] pos;
  logic [NPOS-1:0]            valid;
  logic [ECW-1:0]             ecc_zeros;
  logic [3:0]                 byte_zeros;
  logic [POS_W-1:0]           pos_sel;
  logic                       valid_sel;
  logic [4:0]                 dz_new;
  logic [3:0]                 cnt_in;

  bch8_pos_unpack #(.SECT_BYTES(SECT_BYTES)) u_unpack (
    .vec_i(vec_q), .pos_o(pos), .valid_o(valid)
  );
  bch8_zero_count #(.NBYTES(CODE_BYTES)) u_ecc_zc (
    .bytes_i(stored_ecc_i), .zeros_o(ecc_zeros)
  );
  bch8_zero_count #(.NBYTES(1)) u_dat_zc (
    .bytes_i(mem_rdata_i), .zeros_o(byte_zeros)
  );

  assign pos_sel   = pos[idx_q];
  assign valid_sel = valid[idx_q];
  assign dz_new    = dz_q + 5'(byte_zeros);
  assign cnt_in    = sts_i[13:10];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_wdata_o = 8'hFF;
    unique case (state_q)
      ST_FIX_RD: begin
        mem_req_o  = (left_q != 0) && valid_sel;
        mem_addr_o = pos_sel[ADDR_W+2:3];
      end
      ST_FIX_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pos_sel[ADDR_W+2:3];
        mem_wdata_o = mem_rdata_i ^ (8'b1 << pos_sel[2:0]);
      end
      ST_SCAN_RD: mem_req_o = 1'b1;
      ST_FILL: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vec_q     <= '0;
      left_q    <= '0;
      applied_q <= '0;
      idx_q     <= '0;
      addr_q    <= '0;
      ez_q      <= '0;
      dz_q      <= '0;
      res_q     <= '0;
      uncorr_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vec_q     <= {sts_i[23:16], ecc3_i, ecc2_i, ecc1_i};
          left_q    <= cnt_in;
          applied_q <= '0;
          idx_q     <= '0;
          addr_q    <= '0;
          dz_q      <= '0;
          res_q     <= '0;
          uncorr_q  <= 1'b0;
          if (cnt_in == 0) state_q <= ST_DONE;
          else if (32'(cnt_in) <= MAX_FIX) state_q <= ST_FIX_RD;
          else if (32'(ecc_zeros) > MAX_FIX) begin
            uncorr_q <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            ez_q    <= 4'(ecc_zeros);
            state_q <= ST_SCAN_RD;
          end
        end
        ST_FIX_RD: begin
          if (left_q == 0 || !valid_sel) begin
            res_q   <= applied_q;
            state_q <= ST_DONE;
          end else state_q <= ST_FIX_WR;
        end
        ST_FIX_WR: begin
          idx_q     <= idx_q + 3'd1;
          applied_q <= applied_q + 4'd1;
          left_q    <= left_q - 4'd1;
          state_q   <= ST_FIX_RD;
        end
        ST_SCAN_RD: state_q <= ST_SCAN_CHK;
        ST_SCAN_CHK: begin
          dz_q <= dz_new;
          if (6'(ez_q) + 6'(dz_new) > 6'(MAX_FIX)) begin
            uncorr_q <= 1'b1;
            state_q  <= ST_DONE;
          end else if (addr_q == LAST) begin
            addr_q <= '0;
            res_q  <= 4'(dz_new);
            state_q <= (dz_new == 0) ? ST_DONE : ST_FILL;
          end else begin
            addr_q  <= addr_q + ADDR_W'(1);
            state_q <= ST_SCAN_RD;
          end
        end
        ST_FILL: begin
          addr_q <= addr_q + ADDR_W'(1);
          if (addr_q == LAST) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = state_q == ST_DONE;
  assign result_o = res_q;
  assign uncorr_o = uncorr_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_rmw_same_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && state_q == ST_FIX_WR |->
      $past(mem_req_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o));
  assert_result_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> 32'(result_o) <= MAX_FIX);
  assert_uncorr_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && uncorr_o |-> result_o == 4'd0);
endmodule

// File: tb/sim_bch8_err_fix.sv
module sim_bch8_err_fix;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] sts = '0, ecc1 = '0, ecc2 = '0, ecc3 = '0;
  logic [103:0] stored = '1;
  logic busy, done, uncorr, mem_req, mem_we;
  logic [3:0] result;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [512];
  logic [7:0] exp_m [512];
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  bch8_err_fix u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sts_i(sts),
    .ecc1_i(ecc1), .ecc2_i(ecc2), .ecc3_i(ecc3), .stored_ecc_i(stored),
    .busy_o(busy), .done_o(done), .result_o(result), .uncorr_o(uncorr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int zeros8(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) n++;
    return n;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  task automatic fill_erased(input int nzero);
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    for (int k = 0; k < nzero; k++) begin
      int p = $urandom % 4096;
      mem[p/8][p%8] = 1'b0;
    end
  endtask

  // epos: effective positions (after inversion); field stored = epos ^ 3 (R3, R4)
  task automatic run(input string tag, input int cnt, input logic [7:0][12:0] epos,
                     input bit poke);
    logic [103:0] v;
    int n_exp, ez, dz, wait_cyc, bad;
    bit unc_exp;
    v = '0;
    for (int i = 0; i < 8; i++) v[13*i +: 13] = epos[i] ^ 13'd3;
    for (int i = 0; i < 512; i++) exp_m[i] = mem[i];
    n_exp = 0; unc_exp = 0;
    if (cnt >= 1 && cnt <= 8) begin
      for (int i = 0; i < cnt; i++) begin
        if (epos[i] >= 13'd4096) break;
        exp_m[epos[i] / 8][epos[i] % 8] = ~exp_m[epos[i] / 8][epos[i] % 8];
        n_exp++;
      end
    end else if (cnt > 8) begin
      ez = 0; dz = 0;
      for (int i = 0; i < 13; i++) ez += zeros8(stored[8*i +: 8]);
      for (int i = 0; i < 512; i++) dz += zeros8(mem[i]);
      if (ez + dz <= 8) begin
        n_exp = dz;
        for (int i = 0; i < 512; i++) exp_m[i] = 8'hFF;
      end else unc_exp = 1;
    end
    ecc1 = v[31:0]; ecc2 = v[63:32]; ecc3 = v[95:64];
    sts = {8'($urandom), v[103:96], 2'($urandom), 4'(cnt), 10'($urandom)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      sts[13:10] = 4'd0; ecc1 = ~ecc1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 4000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check({tag, " done seen R8"}, 32'(done), 32'd1);
    check({tag, " result"}, 32'(result), 32'(n_exp));
    check({tag, " uncorr"}, 32'(uncorr), 32'(unc_exp));
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_m[i]) bad++;
    check({tag, " buffer mismatches"}, 32'(bad), 32'd0);
    @(negedge clk);
    check({tag, " done one cycle R8"}, 32'(done), 32'd0);
    check({tag, " result held R8"}, 32'(result), 32'(n_exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0][12:0] ep;
    void'($urandom(32'd4242));
    fill_random();
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 32'(busy), 0);
    check("R1 done at reset", 32'(done), 0);
    check("R1 mem_req at reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) ep[i] = 13'($urandom % 4096);
    run("R2 count zero", 0, ep, 0);

    ep = '0; ep[0] = 13'd0;
    run("R4 first bit", 1, ep, 0);
    ep[0] = 13'd4095;
    run("R4 last bit", 1, ep, 0);
    ep = {13'd4000, 13'd3001, 13'd2222, 13'd1555, 13'd1027, 13'd777, 13'd300, 13'd5};
    run("R3 all eight fields", 8, ep, 0);
    ep = {13'd8191, 13'd4096, 13'd10, 13'd20, 13'd4500, 13'd33, 13'd9, 13'd1};
    run("R5 out of range stops", 6, ep, 0);
    ep = {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd100, 13'd100};
    run("R9 duplicate cancels", 2, ep, 0);
    ep = {13'd1, 13'd2, 13'd3, 13'd4, 13'd5, 13'd6, 13'd7, 13'd4100};
    run("R5 first invalid", 5, ep, 0);
    ep = {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd88, 13'd44};
    run("R8 start ignored while busy", 2, ep, 1);

    stored = '1; fill_erased(0);
    run("R6 clean erased", 15, ep, 0);
    stored = '1; stored[3] = 0; stored[50] = 0; stored[99] = 0;
    mem[7] = 8'hFE; mem[300] = 8'h7F; mem[511] = 8'hEF; mem[200] = 8'hBD;
    run("R6 total eight", 9, ep, 0);
    stored = '1; stored[3] = 0; stored[50] = 0; stored[99] = 0; stored[0] = 0;
    mem[7] = 8'hFE; mem[300] = 8'h7F; mem[511] = 8'hEF; mem[200] = 8'hBD;
    run("R7 total nine", 12, ep, 0);
    stored = '1; for (int i = 0; i < 9; i++) stored[i*11] = 0;
    fill_erased(0);
    run("R7 stored bytes alone", 10, ep, 0);
    stored = '1; fill_random();
    run("R7 random data", 13, ep, 0);

    for (int it = 0; it < 30; it++) begin
      int c = 1 + $urandom % 8;
      fill_random();
      for (int i = 0; i < 8; i++)
        ep[i] = ($urandom % 8 == 0) ? 13'(4096 + $urandom % 4096) : 13'($urandom % 4096);
      run("R5 random positions", c, ep, 0);
    end
    for (int it = 0; it < 10; it++) begin
      int zs = $urandom % 8, zd = $urandom % 8;
      stored = '1;
      for (int k = 0; k < zs; k++) stored[$urandom % 104] = 1'b0;
      fill_erased(zd);
      run("R6 random erased", 9 + $urandom % 7, ep, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule